// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencing Controller

This block is the control unit of a small processor that runs each instruction over several clock cycles. The processor shares one memory between instruction and data accesses and uses one ALU for all arithmetic. The controller is a Moore state machine. Its only data input is the 6-bit major opcode held in the instruction register. Every cycle it drives the select, enable and operation lines that steer the datapath. The registers, the memory and the ALU sit outside the block.

Every instruction begins with two shared steps. The first is a fetch, which also bumps the program counter by one word. The second is a decode, which reads both source registers. During decode the ALU is already working out a possible branch target, before the controller knows the opcode. After decode, the path splits by instruction class:
- Loads take five cycles.
- Stores and register-to-register operations take four.
- Conditional branches and jumps take three.

An opcode outside the supported set sends the machine back to fetch right after decode. The state register can be built with binary or one-hot encoding, chosen by a parameter.

Top module: `mcyc_ctrl`

## Requirements
Control word bit order used below, MSB first (16 bits):
- mem_rd, mem_wr, addr_sel, ir_load, dst_sel, wb_sel, rf_we, alu_a_sel
- alu_b_sel[1:0], alu_op[1:0], pc_src[1:0], pc_we, pc_we_cond

Opcodes:
- register-to-register 000000
- load 100011
- store 101011
- branch-if-equal 000100
- jump 000010

Requirements:
- R1: While `rst` is high at a rising edge, the next cycle shows the fetch control word 16'h9042. Reset is synchronous.
- R2: The fetch word is 16'h9042, which is memory read, IR load, ALU B = 01 (constant 4) and PC write. Fetch is always followed by decode, whatever the opcode.
- R3: The decode word is 16'h00C0, which is ALU A = 0 (PC) and ALU B = 11 (shifted offset), with ALU op add.
- R4: A load runs the sequence fetch, decode, 16'h0180, 16'hA000, 16'h0600 (five cycles):
  - address phase: ALU A = 1, ALU B = 10, op add
  - memory read: addr_sel = 1
  - write-back: rf_we = 1, wb_sel = 1, dst_sel = 0
- R5: A store runs fetch, decode, 16'h0180, then 16'h6000 (mem_wr, addr_sel). It lasts four cycles.
- R6: A register-to-register operation runs fetch, decode, then two steps (four cycles):
  - 16'h0120: ALU A = 1, ALU B = 00, op = 10
  - 16'h0A00: dst_sel, rf_we, wb_sel = 0
- R7: A branch-if-equal runs fetch, decode, then 16'h0115 (three cycles). That word is ALU A = 1, ALU B = 00, op = 01, pc_src = 01 and the conditional PC write.
- R8: A jump runs fetch, decode, then 16'h000A (three cycles). That word is pc_src = 10 and PC write.
- R9: An unsupported opcode seen in decode returns the machine to fetch in the next cycle.
- R10: Every output that a state does not name is 0. mem_rd and mem_wr are never both high.
- R11: A reset raised in the middle of an instruction drops the machine to fetch at the next edge. Execution restarts with decode one cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to fetch, active high |
| opcode | input | OPW (6) | Major opcode from the instruction register |
| mem_rd | output | 1 | Shared memory read enable |
| mem_wr | output | 1 | Shared memory write enable |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| ir_load | output | 1 | Load the instruction register |
| dst_sel | output | 1 | Destination register field: 0 = bits 20:16, 1 = bits 15:11 |
| wb_sel | output | 1 | Write-back data: 0 = ALU result, 1 = memory data register |
| rf_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B: 00 reg B, 01 constant 4, 10 offset, 11 offset shifted by 2 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 from function field |
| pc_src | output | 2 | Next PC: 00 ALU, 01 ALU result register, 10 jump target |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write when the ALU reports equality |

## Verification
All outputs decode straight from the state register. A change of opcode therefore shows on the outputs only from the cycle after the edge that samples it in decode, or in the address step for load versus store. The bench drives the opcode and samples the 16-bit control word on the falling edge. The word it sees there is the state entered at the previous rising edge. For reset, the fetch word is due one edge after `rst` is seen high. Decode is due one edge after release, so the bench checks at the falling edges on either side of that release.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   typedef enum logic [3:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_MADDR  = 4'd2,
      ST_LDRD   = 4'd3,
      ST_LDWB   = 4'd4,
      ST_STWR   = 4'd5,
      ST_REXE   = 4'd6,
      ST_RWB    = 4'd7,
      ST_BRANCH = 4'd8,
      ST_JUMP   = 4'd9
   } state_t;

   localparam int N_STATES = 10;

   // Packed in the same order as the control word in the brief.
   typedef struct packed {
      logic       mem_rd;
      logic       mem_wr;
      logic       addr_sel;
      logic       ir_load;
      logic       dst_sel;
      logic       wb_sel;
      logic       rf_we;
      logic       alu_a_sel;
      logic [1:0] alu_b_sel;
      logic [1:0] alu_op;
      logic [1:0] pc_src;
      logic       pc_we;
      logic       pc_we_cond;
   } ctrl_t;

endpackage

// File: rtl/mcc_next.sv
module mcc_next
   import mcc_pkg::*;
#(
   parameter int               OPW      = 6,
   parameter logic [OPW-1:0]   OP_RTYPE = 6'b000000,
   parameter logic [OPW-1:0]   OP_LOAD  = 6'b100011,
   parameter logic [OPW-1:0]   OP_STORE = 6'b101011,
   parameter logic [OPW-1:0]   OP_BEQ   = 6'b000100,
   parameter logic [OPW-1:0]   OP_JUMP  = 6'b000010
) (
   input  state_t         st,
   input  logic [OPW-1:0] op,
   output state_t         nx
);

   always_comb begin
      nx = ST_FETCH;
      unique case (st)
         ST_FETCH:  nx = ST_DECODE;
         ST_DECODE: begin
            if (op == OP_LOAD || op == OP_STORE) nx = ST_MADDR;
            else if (op == OP_RTYPE)             nx = ST_REXE;
            else if (op == OP_BEQ)               nx = ST_BRANCH;
            else if (op == OP_JUMP)              nx = ST_JUMP;
            else                                 nx = ST_FETCH;
         end
         ST_MADDR:  nx = (op == OP_LOAD) ? ST_LDRD : ST_STWR;
         ST_LDRD:   nx = ST_LDWB;
         ST_REXE:   nx = ST_RWB;
         default:   nx = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mcc_ctrl_map.sv
module mcc_ctrl_map
   import mcc_pkg::*;
(
   input  state_t st,
   output ctrl_t  c
);

   always_comb begin
      c = '0;
      unique case (st)
         ST_FETCH: begin
            c.mem_rd    = 1'b1;
            c.ir_load   = 1'b1;
            c.alu_b_sel = 2'b01;
            c.pc_we     = 1'b1;
         end
         ST_DECODE: c.alu_b_sel = 2'b11;
         ST_MADDR: begin
            c.alu_a_sel = 1'b1;
            c.alu_b_sel = 2'b10;
         end
         ST_LDRD: begin
            c.mem_rd   = 1'b1;
            c.addr_sel = 1'b1;
         end
         ST_LDWB: begin
            c.rf_we  = 1'b1;
            c.wb_sel = 1'b1;
         end
         ST_STWR: begin
            c.mem_wr   = 1'b1;
            c.addr_sel = 1'b1;
         end
         ST_REXE: begin
            c.alu_a_sel = 1'b1;
            c.alu_op    = 2'b10;
         end
         ST_RWB: begin
            c.dst_sel = 1'b1;
            c.rf_we   = 1'b1;
         end
         ST_BRANCH: begin
            c.alu_a_sel  = 1'b1;
            c.alu_op     = 2'b01;
            c.pc_src     = 2'b01;
            c.pc_we_cond = 1'b1;
         end
         ST_JUMP: begin
            c.pc_src = 2'b10;
            c.pc_we  = 1'b1;
         end
         default: c = '0;
      endcase
   end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
   import mcc_pkg::*;
#(
   parameter int             OPW      = 6,
   parameter bit             ONE_HOT  = 1'b0,
   parameter logic [OPW-1:0] OP_RTYPE = 6'b000000,
   parameter logic [OPW-1:0] OP_LOAD  = 6'b100011,
   parameter logic [OPW-1:0] OP_STORE = 6'b101011,
   parameter logic [OPW-1:0] OP_BEQ   = 6'b000100,
   parameter logic [OPW-1:0] OP_JUMP  = 6'b000010
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [OPW-1:0] opcode,
   output logic           mem_rd,
   output logic           mem_wr,
   output logic           addr_sel,
   output logic           ir_load,
   output logic           dst_sel,
   output logic           wb_sel,
   output logic           rf_we,
   output logic           alu_a_sel,
   output logic [1:0]     alu_b_sel,
   output logic [1:0]     alu_op,
   output logic [1:0]     pc_src,
   output logic           pc_we,
   output logic           pc_we_cond
);

   localparam int SW = $bits(state_t);

   if (OPW < 1) begin : g_bad_width
      $error("mcyc_ctrl: OPW must be at least 1");
   end
   if (OP_RTYPE == OP_LOAD || OP_RTYPE == OP_STORE || OP_RTYPE == OP_BEQ ||
       OP_RTYPE == OP_JUMP || OP_LOAD == OP_STORE || OP_LOAD == OP_BEQ ||
       OP_LOAD == OP_JUMP  || OP_STORE == OP_BEQ  || OP_STORE == OP_JUMP ||
       OP_BEQ == OP_JUMP) begin : g_bad_ops
      $error("mcyc_ctrl: opcode parameters must be distinct");
   end

   state_t st, nx;
   ctrl_t  c;

   mcc_next #(
      .OPW(OPW), .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD),
      .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
   ) u_next (
      .st (st),
      .op (opcode),
      .nx (nx)
   );

   if (ONE_HOT) begin : g_onehot
      logic [N_STATES-1:0] oh_q;
      always_ff @(posedge clk) begin
         if (rst) oh_q <= N_STATES'(1) << ST_FETCH;
         else     oh_q <= N_STATES'(1) << nx;
      end
      always_comb begin
         st = ST_FETCH;
         for (int i = 0; i < N_STATES; i++)
            if (oh_q[i]) st = state_t'(SW'(i));
      end
   end else begin : g_binary
      state_t st_q;
      always_ff @(posedge clk) begin
         if (rst) st_q <= ST_FETCH;
         else     st_q <= nx;
      end
      assign st = st_q;
   end

   mcc_ctrl_map u_map (
      .st (st),
      .c  (c)
   );

   assign mem_rd     = c.mem_rd;
   assign mem_wr     = c.mem_wr;
   assign addr_sel   = c.addr_sel;
   assign ir_load    = c.ir_load;
   assign dst_sel    = c.dst_sel;
   assign wb_sel     = c.wb_sel;
   assign rf_we      = c.rf_we;
   assign alu_a_sel  = c.alu_a_sel;
   assign alu_b_sel  = c.alu_b_sel;
   assign alu_op     = c.alu_op;
   assign pc_src     = c.pc_src;
   assign pc_we      = c.pc_we;
   assign pc_we_cond = c.pc_we_cond;

endmodule

// File: rtl/mcc_chk.sv
module mcc_chk (
   input logic       clk,
   input logic       rst,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       addr_sel,
   input logic       ir_load,
   input logic       wb_sel,
   input logic       rf_we,
   input logic [1:0] alu_b_sel,
   input logic [1:0] pc_src,
   input logic       pc_we_cond
);

   // R1: reset held at an edge yields fetch next cycle
   a_r1_reset_fetch: assert property (@(posedge clk) rst |=> ir_load);

   // R2: fetch is always followed by decode
   a_r2_fetch_decode: assert property (@(posedge clk) disable iff (rst)
      ir_load |=> (alu_b_sel == 2'b11 && !ir_load));

   // R3: decode only ever follows fetch
   a_r3_decode_after_fetch: assert property (@(posedge clk) disable iff (rst)
      (alu_b_sel == 2'b11) |-> $past(ir_load));

   // R4: load write-back directly follows the data read
   a_r4_wb_after_read: assert property (@(posedge clk) disable iff (rst)
      (rf_we && wb_sel) |-> $past(mem_rd && addr_sel));

   // R7: branch step is the last of its instruction
   a_r7_branch_ends: assert property (@(posedge clk) disable iff (rst)
      pc_we_cond |=> ir_load);

   // R8: jump step is the last of its instruction
   a_r8_jump_ends: assert property (@(posedge clk) disable iff (rst)
      (pc_src == 2'b10) |=> ir_load);

   // R10: never read and write memory together
   a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

endmodule

bind mcyc_ctrl mcc_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .addr_sel   (addr_sel),
   .ir_load    (ir_load),
   .wb_sel     (wb_sel),
   .rf_we      (rf_we),
   .alu_b_sel  (alu_b_sel),
   .pc_src     (pc_src),
   .pc_we_cond (pc_we_cond)
);

// File: tb/sim_mcyc_ctrl.sv
module sim_mcyc_ctrl;

   localparam logic [15:0] W_FETCH = 16'h9042;
   localparam logic [15:0] W_DEC   = 16'h00C0;
   localparam logic [15:0] W_MADDR = 16'h0180;
   localparam logic [15:0] W_LDRD  = 16'hA000;
   localparam logic [15:0] W_LDWB  = 16'h0600;
   localparam logic [15:0] W_STWR  = 16'h6000;
   localparam logic [15:0] W_REXE  = 16'h0120;
   localparam logic [15:0] W_RWB   = 16'h0A00;
   localparam logic [15:0] W_BR    = 16'h0115;
   localparam logic [15:0] W_JMP   = 16'h000A;

   typedef struct packed {
      logic [5:0]       op;
      logic [2:0]       len;
      logic [4:0][15:0] w;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{6'b100011, 3'd5, {W_LDWB, W_LDRD, W_MADDR, W_DEC, W_FETCH}},
      '{6'b101011, 3'd4, {16'h0, W_STWR, W_MADDR, W_DEC, W_FETCH}},
      '{6'b000000, 3'd4, {16'h0, W_RWB, W_REXE, W_DEC, W_FETCH}},
      '{6'b000100, 3'd3, {16'h0, 16'h0, W_BR, W_DEC, W_FETCH}},
      '{6'b000010, 3'd3, {16'h0, 16'h0, W_JMP, W_DEC, W_FETCH}},
      '{6'b111111, 3'd2, {16'h0, 16'h0, 16'h0, W_DEC, W_FETCH}},
      '{6'b001000, 3'd2, {16'h0, 16'h0, 16'h0, W_DEC, W_FETCH}}
   };
   localparam string TAGS [NV] = '{"R4", "R5", "R6", "R7", "R8", "R9", "R9"};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = '0;
   logic       mem_rd, mem_wr, addr_sel, ir_load, dst_sel, wb_sel, rf_we, alu_a_sel;
   logic [1:0] alu_b_sel, alu_op, pc_src;
   logic       pc_we, pc_we_cond;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   mcyc_ctrl u0 (
      .clk(clk), .rst(rst), .opcode(opcode),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_load(ir_load),
      .dst_sel(dst_sel), .wb_sel(wb_sel), .rf_we(rf_we), .alu_a_sel(alu_a_sel),
      .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
      .pc_we(pc_we), .pc_we_cond(pc_we_cond)
   );

   // Whole-word compare also covers R10 (unnamed outputs are 0).
   task automatic chk(input string tag, input logic [15:0] exp);
      logic [15:0] act;
      act = {mem_rd, mem_wr, addr_sel, ir_load, dst_sel, wb_sel, rf_we, alu_a_sel,
             alu_b_sel, alu_op, pc_src, pc_we, pc_we_cond};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: control word %h, expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1", W_FETCH);
      rst = 1'b0;

      // Vector table: each row starts in fetch and ends back in fetch.
      for (int v = 0; v < NV; v++) begin
         for (int s = 0; s < int'(VECS[v].len); s++) begin
            opcode = VECS[v].op;
            if (s == 0)      chk("R2", VECS[v].w[s]);
            else if (s == 1) chk("R3", VECS[v].w[s]);
            else             chk(TAGS[v], VECS[v].w[s]);
            @(negedge clk);
         end
      end
      chk("R9", W_FETCH);

      // R2: opcode in fetch does not matter; a different value in decode decides.
      opcode = 6'b111111;
      @(negedge clk);
      opcode = 6'b000010;
      chk("R2", W_DEC);
      @(negedge clk);
      chk("R8", W_JMP);
      @(negedge clk);

      // R5: store chosen in address step by opcode seen there
      opcode = 6'b101011;
      repeat (2) @(negedge clk);
      chk("R5", W_MADDR);
      @(negedge clk);
      chk("R5", W_STWR);
      @(negedge clk);

      // R11: reset during load read step
      opcode = 6'b100011;
      repeat (3) @(negedge clk);
      chk("R4", W_LDRD);
      rst = 1'b1;
      @(negedge clk);
      chk("R11", W_FETCH);
      @(negedge clk);
      chk("R11", W_FETCH);
      rst = 1'b0;
      @(negedge clk);
      chk("R11", W_DEC);
      @(negedge clk);
      chk("R11", W_MADDR);

      finish_run();
   end

endmodule